// File: doc/BRIEF.md
# Flash Sector Map Decoder with Boot-Sector Write Guard

This block sits beside the command sequencer of a 128 KiB byte-wide flash array. It turns a 17-bit byte address into one of five sector indices. A strap input chooses whether the 16 KiB boot sector sits at the bottom or the top of the map. The same strap sets where the two 8 KiB parameter sectors and the two main sectors fall.

The block also holds a sticky write-guard flag for the boot sector. Once the flag is set, any program or sector-erase request aimed at the boot sector is refused, and the chip-erase mask leaves the boot sector out. Two things lift the guard: a high-voltage override input, while it is held, or a global reset. The permit decision is combinational, so the sequencer gets its answer in the same cycle it presents a request.

An identification-read helper flags the one address at offset 2 inside the boot sector. At that address it supplies the guard state as a data byte.

Top module: `sect_guard`

## Requirements
- R1: With `top_boot_i` = 0, `sector_o` reports 0 (boot) for 0x00000–0x03FFF, 1 (parameter A) for 0x04000–0x05FFF, 2 (parameter B) for 0x06000–0x07FFF, 3 (main A) for 0x08000–0x0FFFF and 4 (main B) for 0x10000–0x1FFFF.
- R2: With `top_boot_i` = 1, `sector_o` reports 0 for 0x1C000–0x1FFFF, 1 for 0x1A000–0x1BFFF, 2 for 0x18000–0x19FFF, 3 for 0x10000–0x17FFF and 4 for 0x00000–0x0FFFF.
- R3: A one-cycle `lock_set_i` pulse sets the guard flag from the next clock edge on. The flag stays set until reset, and a further pulse changes nothing.
- R4: While the flag is set and `hv_override_i` is 0, a request with `req_valid_i` = 1 and `req_sector_i` = 0 gives `permit_o` = 0.
- R5: While `hv_override_i` = 1, boot-sector requests are permitted and `erase_mask_o` is 5'b11111, even with the flag set. Dropping the override restores the refusal in the same cycle.
- R6: A request with `req_valid_i` = 1 and `req_sector_i` in 1..4 gives `permit_o` = 1, whatever the flag state.
- R7: `erase_mask_o` bit i marks sector i for chip erase. It is 5'b11110 when the flag is set without override, and 5'b11111 otherwise.
- R8: `id_hit_o` = 1 exactly when the address is the boot-sector base plus 2 (0x00002 for bottom boot, 0x1C002 for top boot). `id_data_o` is then {7'b0, flag}; otherwise it is 8'h00.
- R9: `permit_o` is 0 when `req_valid_i` = 0 or when `req_sector_i` is 5, 6 or 7.
- R10: After reset the flag is clear: boot-sector requests are permitted, `erase_mask_o` = 5'b11111, and the identification byte reads 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_i | input | 17 | Byte address to classify |
| top_boot_i | input | 1 | Strap: 0 puts the boot sector at the bottom, 1 at the top |
| lock_set_i | input | 1 | Single-cycle pulse that sets the boot-sector guard flag |
| hv_override_i | input | 1 | While 1, the guard flag is ignored |
| req_valid_i | input | 1 | A program or erase request is presented |
| req_sector_i | input | 3 | Sector index targeted by the request |
| sector_o | output | 3 | Sector index of `addr_i` (0 boot, 1–2 parameter, 3–4 main) |
| permit_o | output | 1 | Request may proceed |
| erase_mask_o | output | 5 | Per-sector chip-erase enables, bit i for sector i |
| id_hit_o | output | 1 | Address is the guard-status location |
| id_data_o | output | 8 | Identification byte carrying the guard flag on bit 0 |

## Verification
The properties relate the combinational outputs to the inputs in the same sampled cycle. They therefore assume that address, strap, override and request fields are stable around each rising edge and that the guard pulse lasts one cycle. The bench changes every input 2 ns after a rising edge and compares results at the falling edge. It raises the guard pulse alone, in a cycle with no scored check, so that no expected value straddles the edge where the flag changes. Requests are presented with out-of-range sector codes and with `req_valid_i` low, as well as with legal codes.

// File: rtl/sg_pkg.sv
package sg_pkg;
  localparam int unsigned SECT_N   = 5;
  localparam int unsigned SECT_W   = 3;
  localparam int unsigned EDGE_N   = SECT_N - 1;
  localparam int unsigned BOOT_IDX = 0;

  typedef enum logic [SECT_W-1:0] {
    SEC_BOOT  = 3'd0,
    SEC_PAR_A = 3'd1,
    SEC_PAR_B = 3'd2,
    SEC_MAIN_A = 3'd3,
    SEC_MAIN_B = 3'd4
  } sect_e;
endpackage

// File: rtl/sg_rst_sync.sv
module sg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sg_map_decode.sv
module sg_map_decode
  import sg_pkg::*;
#(
  parameter int unsigned ADDR_W      = 17,
  parameter int unsigned BOOT_BYTES  = 16384,
  parameter int unsigned PARAM_BYTES = 8192,
  parameter int unsigned MAIN_A_BYTES = 32768,
  parameter int unsigned ID_OFS      = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              top_boot_i,
  output logic [SECT_W-1:0] sector_o,
  output logic              id_hit_o
);
  localparam int unsigned TOTAL = 1 << ADDR_W;
  localparam logic [ADDR_W:0] EDGE0 = (ADDR_W+1)'(BOOT_BYTES);
  localparam logic [ADDR_W:0] EDGE1 = EDGE0 + (ADDR_W+1)'(PARAM_BYTES);
  localparam logic [ADDR_W:0] EDGE2 = EDGE1 + (ADDR_W+1)'(PARAM_BYTES);
  localparam logic [ADDR_W:0] EDGE3 = EDGE2 + (ADDR_W+1)'(MAIN_A_BYTES);
  localparam logic [ADDR_W-1:0] TOP_BASE = ADDR_W'(TOTAL - BOOT_BYTES);
  localparam logic [ADDR_W-1:0] ID_OFFSET = ADDR_W'(ID_OFS);

  function automatic logic [ADDR_W:0] edge_at(input int unsigned k);
    case (k)
      0:       edge_at = EDGE0;
      1:       edge_at = EDGE1;
      2:       edge_at = EDGE2;
      default: edge_at = EDGE3;
    endcase
  endfunction

  // The top-boot map is the bit-inverted image of the bottom-boot map.
  logic [ADDR_W:0]     mir_addr;
  logic [EDGE_N-1:0]   passed;
  logic [SECT_W-1:0]   count;
  logic [ADDR_W-1:0]   id_addr;

  always_comb mir_addr = {1'b0, addr_i ^ {ADDR_W{top_boot_i}}};

  for (genvar g = 0; g < EDGE_N; g++) begin : g_edge
    assign passed[g] = (mir_addr >= edge_at(g));
  end

  always_comb begin
    count = '0;
    for (int k = 0; k < EDGE_N; k++) count = count + SECT_W'(passed[k]);
  end

  always_comb id_addr = (top_boot_i ? TOP_BASE : '0) + ID_OFFSET;

  assign sector_o = count;
  assign id_hit_o = (addr_i == id_addr);
endmodule

// File: rtl/sg_lock_reg.sv
module sg_lock_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  output logic lock_o
);
  logic lock_q;
  logic lock_en;
  logic lock_d;

  always_comb begin
    lock_en = set_i & ~lock_q;
    lock_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lock_q <= 1'b0;
    else if (lock_en) lock_q <= lock_d;
  end

  assign lock_o = lock_q;
endmodule

// File: rtl/sg_permit.sv
module sg_permit
  import sg_pkg::*;
(
  input  logic              lock_i,
  input  logic              hv_i,
  input  logic              req_valid_i,
  input  logic [SECT_W-1:0] req_sector_i,
  output logic              permit_o,
  output logic [SECT_N-1:0] erase_mask_o
);
  logic guard;
  logic legal;
  logic is_boot;

  always_comb begin
    guard   = lock_i & ~hv_i;
    legal   = (req_sector_i <= SECT_W'(SECT_N - 1));
    is_boot = (req_sector_i == SECT_W'(BOOT_IDX));
    permit_o = req_valid_i & legal & ~(is_boot & guard);
  end

  for (genvar g = 0; g < SECT_N; g++) begin : g_mask
    if (g == BOOT_IDX) begin : g_boot
      assign erase_mask_o[g] = ~guard;
    end else begin : g_free
      assign erase_mask_o[g] = 1'b1;
    end
  end
endmodule

// File: rtl/sect_guard.sv
module sect_guard
  import sg_pkg::*;
#(
  parameter int unsigned ADDR_W       = 17,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned BOOT_BYTES   = 16384,
  parameter int unsigned PARAM_BYTES  = 8192,
  parameter int unsigned MAIN_A_BYTES = 32768,
  parameter int unsigned ID_OFS       = 2,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              top_boot_i,
  input  logic              lock_set_i,
  input  logic              hv_override_i,
  input  logic              req_valid_i,
  input  logic [2:0]        req_sector_i,
  output logic [2:0]        sector_o,
  output logic              permit_o,
  output logic [4:0]        erase_mask_o,
  output logic              id_hit_o,
  output logic [DATA_W-1:0] id_data_o
);
  logic rst_sync_n;
  logic lock;

  sg_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sg_map_decode #(
    .ADDR_W       (ADDR_W),
    .BOOT_BYTES   (BOOT_BYTES),
    .PARAM_BYTES  (PARAM_BYTES),
    .MAIN_A_BYTES (MAIN_A_BYTES),
    .ID_OFS       (ID_OFS)
  ) i_map (
    .addr_i     (addr_i),
    .top_boot_i (top_boot_i),
    .sector_o   (sector_o),
    .id_hit_o   (id_hit_o)
  );

  sg_lock_reg i_lock (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .set_i  (lock_set_i),
    .lock_o (lock)
  );

  sg_permit i_permit (
    .lock_i       (lock),
    .hv_i         (hv_override_i),
    .req_valid_i  (req_valid_i),
    .req_sector_i (req_sector_i),
    .permit_o     (permit_o),
    .erase_mask_o (erase_mask_o)
  );

  assign id_data_o = id_hit_o ? {{(DATA_W-1){1'b0}}, lock} : '0;
endmodule

// File: rtl/sg_checker.sv
module sg_checker #(
  parameter int unsigned ADDR_W     = 17,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned BOOT_BYTES = 16384
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_i,
  input logic              top_boot_i,
  input logic              hv_override_i,
  input logic              req_valid_i,
  input logic [2:0]        req_sector_i,
  input logic [2:0]        sector_o,
  input logic              permit_o,
  input logic [4:0]        erase_mask_o,
  input logic              id_hit_o,
  input logic [DATA_W-1:0] id_data_o
);
  localparam logic [ADDR_W-1:0] BOOT_LIM = ADDR_W'(BOOT_BYTES);
  localparam logic [ADDR_W-1:0] TOP_BASE = ADDR_W'((1 << ADDR_W) - BOOT_BYTES);

  // R1
  bottom_boot_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!top_boot_i && addr_i < BOOT_LIM) |-> sector_o == 3'd0);
  // R2
  top_boot_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (top_boot_i && addr_i >= TOP_BASE) |-> sector_o == 3'd0);
  // R1
  sector_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sector_o <= 3'd4);
  // R3
  guard_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hv_override_i && $past(!hv_override_i && !erase_mask_o[0])) |-> !erase_mask_o[0]);
  // R4
  boot_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_sector_i == 3'd0 && !hv_override_i && !erase_mask_o[0]) |-> !permit_o);
  // R5
  override_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hv_override_i |-> erase_mask_o == 5'h1F);
  // R6
  free_sector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_sector_i >= 3'd1 && req_sector_i <= 3'd4) |-> permit_o);
  // R7
  mask_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_mask_o[4:1] == 4'hF);
  // R8
  id_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !id_hit_o |-> id_data_o == '0);
  // R8
  id_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    id_hit_o |-> id_data_o[DATA_W-1:1] == '0);
  // R9
  no_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid_i || req_sector_i > 3'd4) |-> !permit_o);
endmodule

bind sect_guard sg_checker #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .BOOT_BYTES (BOOT_BYTES)
) i_sg_checker (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .addr_i        (addr_i),
  .top_boot_i    (top_boot_i),
  .hv_override_i (hv_override_i),
  .req_valid_i   (req_valid_i),
  .req_sector_i  (req_sector_i),
  .sector_o      (sector_o),
  .permit_o      (permit_o),
  .erase_mask_o  (erase_mask_o),
  .id_hit_o      (id_hit_o),
  .id_data_o     (id_data_o)
);

// File: tb/test_sect_guard.sv
module test_sect_guard;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [16:0] addr_i;
  logic        top_boot_i;
  logic        lock_set_i;
  logic        hv_override_i;
  logic        req_valid_i;
  logic [2:0]  req_sector_i;
  logic [2:0]  sector_o;
  logic        permit_o;
  logic [4:0]  erase_mask_o;
  logic        id_hit_o;
  logic [7:0]  id_data_o;

  always #10 clk = ~clk;

  sect_guard i_sect_guard (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .top_boot_i(top_boot_i),
    .lock_set_i(lock_set_i), .hv_override_i(hv_override_i),
    .req_valid_i(req_valid_i), .req_sector_i(req_sector_i),
    .sector_o(sector_o), .permit_o(permit_o), .erase_mask_o(erase_mask_o),
    .id_hit_o(id_hit_o), .id_data_o(id_data_o)
  );

  typedef struct {
    logic [2:0] sector;
    logic       permit;
    logic [4:0] mask;
    logic       hit;
    logic [7:0] data;
    string      tag;
  } exp_t;

  exp_t sb_q[$];
  int   n_checks = 0;
  int   n_fails  = 0;
  logic exp_lock = 1'b0;
  bit   done     = 1'b0;

  function automatic logic [2:0] ref_sector(input logic [16:0] a, input logic top);
    if (!top) begin
      if (a < 17'h04000)      return 3'd0;
      else if (a < 17'h06000) return 3'd1;
      else if (a < 17'h08000) return 3'd2;
      else if (a < 17'h10000) return 3'd3;
      else                    return 3'd4;
    end
    if (a >= 17'h1C000)      return 3'd0;
    else if (a >= 17'h1A000) return 3'd1;
    else if (a >= 17'h18000) return 3'd2;
    else if (a >= 17'h10000) return 3'd3;
    return 3'd4;
  endfunction

  task automatic apply(input logic [16:0] a, input logic top, input logic v,
                       input logic [2:0] s, input logic hv, input string tag);
    exp_t e;
    @(posedge clk);
    #2;
    addr_i = a; top_boot_i = top; req_valid_i = v; req_sector_i = s; hv_override_i = hv;
    e.sector = ref_sector(a, top);
    e.permit = v && (s <= 3'd4) && ((s != 3'd0) || !exp_lock || hv);
    e.mask   = (exp_lock && !hv) ? 5'h1E : 5'h1F;
    e.hit    = (a == (top ? 17'h1C002 : 17'h00002));
    e.data   = e.hit ? {7'b0, exp_lock} : 8'h00;
    e.tag    = tag;
    sb_q.push_back(e);
  endtask

  task automatic pulse_lock();
    @(posedge clk);
    #2 lock_set_i = 1'b1;
    @(posedge clk);
    #2 lock_set_i = 1'b0;
    exp_lock = 1'b1;
  endtask

  task automatic do_reset();
    @(posedge clk);
    #2 rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    exp_lock = 1'b0;
  endtask

  // Monitor: compare one scoreboard entry per falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        exp_t e;
        logic bad;
        e = sb_q.pop_front();
        n_checks++;
        bad = (sector_o !== e.sector) || (permit_o !== e.permit) || (erase_mask_o !== e.mask)
           || (id_hit_o !== e.hit) || (id_data_o !== e.data);
        if (bad) begin
          n_fails++;
          $display("FAIL %s: got sector=%0d permit=%0b mask=%b hit=%0b data=%h, expected sector=%0d permit=%0b mask=%b hit=%0b data=%h",
                   e.tag, sector_o, permit_o, erase_mask_o, id_hit_o, id_data_o,
                   e.sector, e.permit, e.mask, e.hit, e.data);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fails++;
      n_checks++;
      $display("FAIL watchdog: got running, expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; addr_i = '0; top_boot_i = 1'b0; lock_set_i = 1'b0;
    hv_override_i = 1'b0; req_valid_i = 1'b0; req_sector_i = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R10: reset state
    apply(17'h00002, 1'b0, 1'b1, 3'd0, 1'b0, "R10 reset state");

    // R1: bottom-boot boundaries
    begin
      logic [16:0] pts [10] = '{17'h00000, 17'h03FFF, 17'h04000, 17'h05FFF, 17'h06000,
                                17'h07FFF, 17'h08000, 17'h0FFFF, 17'h10000, 17'h1FFFF};
      foreach (pts[i]) apply(pts[i], 1'b0, 1'b0, 3'd0, 1'b0, "R1 bottom map");
    end
    // R2: top-boot boundaries
    begin
      logic [16:0] pts [10] = '{17'h1FFFF, 17'h1C000, 17'h1BFFF, 17'h1A000, 17'h19FFF,
                                17'h18000, 17'h17FFF, 17'h10000, 17'h0FFFF, 17'h00000};
      foreach (pts[i]) apply(pts[i], 1'b1, 1'b0, 3'd0, 1'b0, "R2 top map");
    end

    // R9, R6: request codes with guard clear
    for (int s = 0; s < 8; s++) apply(17'h08000, 1'b0, 1'b1, 3'(s), 1'b0, "R9 R6 codes unlocked");
    apply(17'h08000, 1'b0, 1'b0, 3'd3, 1'b0, "R9 no valid");

    // R3: set guard
    pulse_lock();
    apply(17'h00002, 1'b0, 1'b1, 3'd0, 1'b0, "R3 R4 boot refused, id locked");
    apply(17'h1C002, 1'b1, 1'b1, 3'd0, 1'b0, "R4 R8 top id locked");
    apply(17'h1C002, 1'b0, 1'b0, 3'd0, 1'b0, "R8 bottom miss at top loc");
    apply(17'h00003, 1'b0, 1'b0, 3'd0, 1'b0, "R8 miss offset 3");
    for (int s = 1; s < 5; s++) apply(17'h10000, 1'b1, 1'b1, 3'(s), 1'b0, "R6 R7 free sectors locked");
    apply(17'h10000, 1'b1, 1'b1, 3'd6, 1'b0, "R9 illegal code locked");

    // R5: override and release
    apply(17'h00002, 1'b0, 1'b1, 3'd0, 1'b1, "R5 override permits");
    apply(17'h00002, 1'b0, 1'b1, 3'd0, 1'b0, "R5 override removed");
    apply(17'h1C002, 1'b1, 1'b1, 3'd0, 1'b1, "R5 R7 override top");

    // R3: second pulse has no effect, flag still set
    pulse_lock();
    apply(17'h00002, 1'b0, 1'b1, 3'd0, 1'b0, "R3 repeated set");

    // R10: reset clears guard
    do_reset();
    apply(17'h00002, 1'b0, 1'b1, 3'd0, 1'b0, "R10 after reset");
    apply(17'h1C002, 1'b1, 1'b1, 3'd0, 1'b0, "R10 R7 after reset top");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule